// File: doc/BRIEF.md
# Byte-Lane Enable Write Gate

This block sits between a CPU bus and a small array of 32-bit registers that cannot use per-access byte strobes. Software first writes a separate lane control register whose four enable bits choose which byte lanes of the target word may change. Each later data write updates only those lanes. The enables stay in force for every following data write until the control register is written again.

A combinational helper turns the size and the low two address bits of a store into the control-register value that software must program before that store. It also flags a halfword store that would run past the end of the word. When a data write carries that illegal size and offset combination, nothing is written and an error pulse is raised. When a control write and a data write fall in the same cycle, the control write takes effect first, so the new enables govern that data write.

Top module: `lane_gate_top`

## Requirements
- R1: After reset, lanes_o is 4'hF (all four lanes enabled), err_o is 0 and every word of the array reads 0.
- R2: A control write loads lanes_o from ctl_wdata_i[6:3], with bit 3 enabling byte 0 and bit 6 enabling byte 3. lanes_o is visible one cycle later. All other bits of ctl_wdata_i have no effect.
- R3: A legal data write changes byte k of the addressed word to wr_data_i[8k+7:8k] only when lane k is enabled. Disabled bytes and all other words keep their values.
- R4: The lane enables persist unchanged across data writes until the next control write.
- R5: If a control write and a data write happen in the same cycle, the newly written enables govern that data write.
- R6: For a word store (wr_size_i = 2), mask_o is 8'hF8 (bits 7:3 set).
- R7: For a byte store (wr_size_i = 0), mask_o is 1 shifted left by wr_off_i, placed at bits 6:3 (8'h08 << wr_off_i).
- R8: For a halfword store (wr_size_i = 1) with wr_off_i of 0 to 2, mask_o is binary 11 shifted left by wr_off_i, placed at bits 6:3 (8'h18 << wr_off_i).
- R9: A halfword store with wr_off_i = 3, or wr_size_i = 3 (reserved), is illegal. In that case illegal_o is 1 and mask_o is 0. A data write carrying it changes no byte, and err_o is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Lane control register write strobe |
| ctl_wdata_i | input | 32 | Lane control write data; bits 6:3 are lane enables |
| wr_en_i | input | 1 | Data write strobe |
| wr_addr_i | input | 3 | Word index of the data write |
| wr_size_i | input | 2 | Store size: 0 byte, 1 halfword, 2 word, 3 reserved |
| wr_off_i | input | 2 | Low two byte-address bits of the store |
| wr_data_i | input | 32 | Data write word, byte k on bits 8k+7:8k |
| rd_addr_i | input | 3 | Read word index |
| rd_data_o | output | 32 | Combinational read of the addressed word |
| lanes_o | output | 4 | Current lane enables |
| mask_o | output | 8 | Control value to program for the given size and offset |
| illegal_o | output | 1 | Size/offset combination is illegal |
| err_o | output | 1 | One-cycle pulse after a rejected data write |

## Verification
Data writes are made under several lane patterns: all lanes, a single lane, a non-adjacent pair, and no lanes. This separates correct per-byte gating from whole-word or inverted gating. A sequence of two writes without a control write in between shows that the enables persist. A control value with bit 7 and bits 2:0 set but bits 6:3 clear shows whether the wrong bits are decoded. A same-cycle control and data write separates bypassing of the new enables from use of the stale ones. The helper is swept over every size and offset, including both illegal codes, and an illegal write is followed by readback of the word it targeted.

// File: rtl/lane_gate_pkg.sv
package lane_gate_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_mask_calc.sv
module lane_mask_calc
  import lane_gate_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LSB    = 3,
  parameter int unsigned MASK_W = 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [LANES-1:0]  lanes_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              illegal_o
);
  acc_size_e size;
  assign size = acc_size_e'(size_i);

  always_comb begin
    lanes_o   = '0;
    illegal_o = 1'b0;
    unique case (size)
      SZ_BYTE: lanes_o = LANES'(1) << off_i;
      SZ_HALF: begin
        if (off_i == OFF_W'(LANES - 1)) illegal_o = 1'b1;
        else lanes_o = LANES'(3) << off_i;
      end
      SZ_WORD: lanes_o = {LANES{1'b1}};
      default: illegal_o = 1'b1;
    endcase
  end

  // full-word setup also sets the bit above the lane field
  always_comb begin
    mask_o = MASK_W'(lanes_o) << LSB;
    if (size == SZ_WORD) mask_o = mask_o | (MASK_W'(1) << (LSB + LANES));
  end

  always_comb begin
    if (size == SZ_BYTE)
      assert_byte_one_lane_R7: assert ($countones(lanes_o) == 1);
    if (size == SZ_HALF && !illegal_o)
      assert_half_two_lanes_R8: assert ($countones(lanes_o) == 2);
    if (illegal_o)
      assert_illegal_no_mask_R9: assert (mask_o == '0);
  end
endmodule

// File: rtl/lane_ctl_reg.sv
module lane_ctl_reg #(
  parameter int unsigned LANES = 4,
  parameter int unsigned LSB   = 3,
  parameter int unsigned CW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CW-1:0]    wdata_i,
  output logic [LANES-1:0] lanes_o,
  output logic [LANES-1:0] next_o
);
  logic [LANES-1:0] field;
  assign field = wdata_i[LSB +: LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lanes_o <= {LANES{1'b1}};
    else if (we_i) lanes_o <= field;
  end

  // setup write ordered ahead of a same-cycle data write
  assign next_o = we_i ? field : lanes_o;

  assert_ctl_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> lanes_o == $past(wdata_i[LSB +: LANES]));
  assert_ctl_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(lanes_o));
endmodule

// File: rtl/lane_reg_array.sv
module lane_reg_array
  import lane_gate_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [LANES-1:0][BYTE_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]             hit;

  for (genvar w = 0; w < DEPTH; w++) begin : g_hit
    assign hit[w] = we_i && (addr_i == AW'(w));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++)
        for (int b = 0; b < LANES; b++)
          if (hit[w] && be_i[b]) mem_q[w][b] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
  end

  assign rd_data_o = (32'(rd_addr_i) < DEPTH) ? mem_q[rd_addr_i] : '0;

  for (genvar w = 0; w < DEPTH; w++) begin : g_chk
    assert_idle_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit[w] |=> $stable(mem_q[w]));
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assert_masked_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit[w] && !be_i[b]) |=> $stable(mem_q[w][b]));
      assert_written_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit[w] && be_i[b]) |=> mem_q[w][b] == $past(wdata_i[b*BYTE_W +: BYTE_W]));
    end
  end
endmodule

// File: rtl/lane_gate_top.sv
module lane_gate_top
  import lane_gate_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LSB    = 3,
  parameter int unsigned MASK_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [DW-1:0]     ctl_wdata_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [1:0]        wr_size_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [LANES-1:0]  lanes_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              illegal_o,
  output logic              err_o
);
  logic [LANES-1:0] lanes_next;
  logic [LANES-1:0] size_lanes;
  logic [LANES-1:0] be;
  logic             do_wr;

  lane_ctl_reg #(.LANES(LANES), .LSB(LSB), .CW(DW)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .lanes_o (lanes_o),
    .next_o  (lanes_next)
  );

  lane_mask_calc #(.LANES(LANES), .LSB(LSB), .MASK_W(MASK_W)) u_calc (
    .size_i    (wr_size_i),
    .off_i     (wr_off_i),
    .lanes_o   (size_lanes),
    .mask_o    (mask_o),
    .illegal_o (illegal_o)
  );

  assign do_wr = wr_en_i && !illegal_o;
  assign be    = lanes_next & {LANES{!illegal_o}};

  lane_reg_array #(.DEPTH(DEPTH), .LANES(LANES)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (do_wr),
    .addr_i    (wr_addr_i),
    .be_i      (be),
    .wdata_i   (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else err_o <= wr_en_i && illegal_o;
  end

  assert_err_raise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && illegal_o) |=> err_o);
  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && illegal_o) |=> !err_o);
  assert_illegal_nowrite_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && illegal_o && wr_addr_i == rd_addr_i) |=> $stable(rd_data_o));
  assert_size_lanes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> size_lanes == '0);
endmodule

// File: tb/lane_gate_top_tb.sv
module lane_gate_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 1'b0;
  logic [31:0] ctl_wdata_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [1:0]  wr_size_i = 2'd2;
  logic [1:0]  wr_off_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  lanes_o;
  logic [7:0]  mask_o;
  logic        illegal_o;
  logic        err_o;

  lane_gate_top u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct { logic [2:0] addr; logic [31:0] exp; string req; } item_t;
  item_t       sb_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [31:0] model [8];
  logic [3:0]  m_lanes = 4'hF;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected words and compares against the read port
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        rd_addr_i = it.addr;
        #1;
        check(it.req, rd_data_o, it.exp);
      end
    end
  end

  task automatic expect_word(logic [2:0] a, string req);
    item_t it;
    it.addr = a; it.exp = model[a]; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  function automatic bit legal(logic [1:0] sz, logic [1:0] off);
    return !(sz == 2'd3 || (sz == 2'd1 && off == 2'd3));
  endfunction

  task automatic op(bit cwe, logic [31:0] cval, bit we, logic [2:0] a,
                    logic [1:0] sz, logic [1:0] off, logic [31:0] d);
    @(negedge clk_i);
    ctl_we_i = cwe; ctl_wdata_i = cval;
    wr_en_i = we; wr_addr_i = a; wr_size_i = sz; wr_off_i = off; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    ctl_we_i = 0; wr_en_i = 0;
    if (cwe) m_lanes = cval[6:3];
    if (we && legal(sz, off))
      for (int b = 0; b < 4; b++)
        if (m_lanes[b]) model[a][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic mask_chk(logic [1:0] sz, logic [1:0] off, logic [7:0] exp, string req);
    @(negedge clk_i);
    wr_size_i = sz; wr_off_i = off;
    #1;
    check(req, {24'd0, mask_o}, {24'd0, exp});
    check(req, {31'd0, illegal_o}, {31'd0, !legal(sz, off)});
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    @(negedge clk_i);
    check("R1 lanes", {28'd0, lanes_o}, 32'hF);
    check("R1 err", {31'd0, err_o}, 32'd0);
    expect_word(3'd0, "R1 word0");
    expect_word(3'd7, "R1 word7");

    // R3 full word under default lanes
    op(0, 0, 1, 3'd1, 2'd2, 2'd0, 32'h11223344);
    expect_word(3'd1, "R3 full word");

    // R6 R7 R8 R9 helper sweep
    mask_chk(2'd2, 2'd0, 8'hF8, "R6 word mask");
    for (int o = 0; o < 4; o++) mask_chk(2'd0, 2'(o), 8'h08 << o, "R7 byte mask");
    for (int o = 0; o < 3; o++) mask_chk(2'd1, 2'(o), 8'h18 << o, "R8 half mask");
    mask_chk(2'd1, 2'd3, 8'h00, "R9 half off3");
    mask_chk(2'd3, 2'd1, 8'h00, "R9 reserved size");

    // R2 single lane 2 then R3 gated write
    op(1, 32'h0000_0020, 0, 3'd0, 2'd0, 2'd2, 0);
    check("R2 lanes lane2", {28'd0, lanes_o}, 32'h4);
    op(0, 0, 1, 3'd1, 2'd0, 2'd2, 32'hAABBCCDD);
    expect_word(3'd1, "R3 single lane");
    // R4 persistence
    op(0, 0, 1, 3'd1, 2'd0, 2'd2, 32'h55667788);
    check("R4 lanes kept", {28'd0, lanes_o}, 32'h4);
    expect_word(3'd1, "R4 second write");

    // R2 stray bits ignored: bit7 and 2:0 set, lane field zero
    op(1, 32'hFFFF_FF87, 0, 3'd0, 2'd2, 2'd0, 0);
    check("R2 stray bits", {28'd0, lanes_o}, 32'h0);
    op(0, 0, 1, 3'd1, 2'd2, 2'd0, 32'hFFFFFFFF);
    expect_word(3'd1, "R3 no lanes");

    // R9 illegal writes with all lanes on
    op(1, 32'h0000_0078, 0, 3'd0, 2'd2, 2'd0, 0);
    op(0, 0, 1, 3'd1, 2'd1, 2'd3, 32'h0BAD0BAD);
    check("R9 err pulse", {31'd0, err_o}, 32'd1);
    expect_word(3'd1, "R9 no write half3");
    check("R9 err cleared", {31'd0, err_o}, 32'd0);
    op(0, 0, 1, 3'd1, 2'd3, 2'd0, 32'h0BAD0BAD);
    check("R9 err rsvd", {31'd0, err_o}, 32'd1);
    expect_word(3'd1, "R9 no write rsvd");

    // R5 same-cycle setup governs the write
    op(1, 32'h0000_0018, 1, 3'd2, 2'd1, 2'd0, 32'hDEADBEEF);
    expect_word(3'd2, "R5 same cycle");
    expect_word(3'd1, "R3 other word kept");

    // R3 non-adjacent lanes 1 and 3 at last word
    op(1, 32'h0000_0050, 0, 3'd0, 2'd2, 2'd0, 0);
    op(0, 0, 1, 3'd7, 2'd2, 2'd0, 32'hCAFEF00D);
    expect_word(3'd7, "R3 lanes 1 and 3");
    check("R4 lanes 1010", {28'd0, lanes_o}, 32'hA);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule